// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller for one cache in a snooping multiprocessor where writes to shared data are pushed to the other copies instead of removing them. A direct-mapped tag array holds a presence bit, a tag and a protocol state for each line. The protocol has four stable states: sole-clean, sole-dirty, shared-clean and shared-dirty-owner. A present line is always usable, and nothing seen on the bus ever removes one.

On the processor side, the controller serves reads and writes. It allocates on misses of either kind. It writes a dirty victim back before refilling the line. A store to a shared line goes out as a single-word update on the bus. On the snoop side, every bus transaction from the other caches is checked against the tags. The controller reports on a shared-copies wire whether it holds the line. It supplies the whole line when another cache reads a line that this cache owns dirty. Snooped word updates are merged into the local copy.

The bus side is a request/grant handshake. The controller raises a request with a command and an address and holds them steady. The transaction completes in the cycle the grant is high. In that same cycle the controller samples the other caches' shared wire and, for reads, the fill line.

Top module: `upd_snoop_ctrl`

## Requirements
- R1: After reset no line is present, cpu_done and bus_req are low, and a snooped read sees snp_shared and snp_flush low.
- R2: A read miss issues one bus read (bus_cmd 1). It fills the line as sole-clean if bus_shared_in is low in the grant cycle, or as shared-clean if it is high. The read word is returned with cpu_done.
- R3: A write miss issues a bus read. If the shared wire is high at that grant, a word update (bus_cmd 2) follows and the line ends shared-dirty-owner. If the wire is low, no update is sent and the line ends sole-dirty.
- R4: A write hit on a sole-clean or sole-dirty line completes with no bus transaction and leaves the line sole-dirty.
- R5: A write hit on a shared line issues one word update that carries the word address on bus_addr and the word on bus_word. The line becomes shared-dirty-owner if the wire is high at grant, else sole-dirty. cpu_done follows the update grant by one cycle.
- R6: A miss whose victim is dirty first issues a flush (bus_cmd 3) of the whole victim line at its base address, followed directly by the bus read. A clean victim is dropped silently.
- R7: A snooped read (snp_cmd 1) raises snp_shared in the same cycle exactly when the line is present. On a dirty line it also raises snp_flush, drives the line on snp_line and leaves the line shared-dirty-owner. A sole-clean line becomes shared-clean.
- R8: A snooped word update (snp_cmd 2) to a present line writes the word into the copy and leaves the line shared-clean. To an absent line it has no effect.
- R9: No snooped transaction removes a line; a line hit by snoops still hits afterwards.
- R10: bus_req, once raised, holds a nonzero bus_cmd and a stable bus_addr until bus_gnt.
- R11: cpu_done is a one-cycle pulse.
- R12: A snooped flush (snp_cmd 3) is ignored: no snp_shared, no snp_flush, and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 for write |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Request complete (pulse) |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 1 read, 2 word update, 3 flush |
| bus_addr | output | ADDR_W | Line base (read, flush) or word address (update) |
| bus_word | output | DATA_W | Update word |
| bus_line | output | WORDS*DATA_W | Flushed line, word 0 in low bits |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_shared_in | input | 1 | Other caches hold the line, sampled with grant |
| bus_fill | input | WORDS*DATA_W | Fill line for a bus read, valid with grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_word | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies the line |
| snp_line | output | WORDS*DATA_W | Supplied line |

## Verification
A wrong line state does not show at the ports when it occurs. It shows at the next access that depends on it. A clean line wrongly marked shared sends an unwanted word update on the next store. A lost dirty mark drops the flush at eviction, and the lost data then shows up as a stale word on a later refill. A wrong owner mark flips snp_flush in the same cycle as the next snooped read. For that reason the stimulus always follows a state change with the access that exposes it, usually within one or two operations.

// File: rtl/ucoh_pkg.sv
package ucoh_pkg;
    typedef enum logic [1:0] {
        LS_EXCL  = 2'd0,
        LS_MOD   = 2'd1,
        LS_SHCLN = 2'd2,
        LS_SHMOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_READ   = 2'd1,
        BC_UPDATE = 2'd2,
        BC_FLUSH  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_WBACK,
        FS_FILL,
        FS_UPDATE
    } fsm_e;

    function automatic logic is_dirty(input line_st_e s);
        return (s == LS_MOD) || (s == LS_SHMOD);
    endfunction
endpackage

// File: rtl/ucoh_tag_store.sv
module ucoh_tag_store
    import ucoh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 3,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_st_e         wr_st,
    output logic             a_present,
    output logic [TAG_W-1:0] a_tag,
    output line_st_e         a_st,
    output logic             b_present,
    output logic [TAG_W-1:0] b_tag,
    output line_st_e         b_st
);
    logic [LINES-1:0] present_d, present_q;
    logic [TAG_W-1:0] tag_d [LINES];
    logic [TAG_W-1:0] tag_q [LINES];
    line_st_e         st_d  [LINES];
    line_st_e         st_q  [LINES];

    always_comb begin
        present_d = present_q;
        tag_d     = tag_q;
        st_d      = st_q;
        if (wr_en) begin
            present_d[wr_idx] = 1'b1;
            tag_d[wr_idx]     = wr_tag;
            st_d[wr_idx]      = wr_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LS_EXCL;
            end
        end else begin
            present_q <= present_d;
            tag_q     <= tag_d;
            st_q      <= st_d;
        end
    end

    assign a_present = present_q[a_idx];
    assign a_tag     = tag_q[a_idx];
    assign a_st      = st_q[a_idx];
    assign b_present = present_q[b_idx];
    assign b_tag     = tag_q[b_idx];
    assign b_st      = st_q[b_idx];
endmodule

// File: rtl/ucoh_data_store.sv
module ucoh_data_store #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W  = $clog2(LINES),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORDS-1:0]  wr_mask,
    input  logic [LINE_W-1:0] wr_line,
    output logic [LINE_W-1:0] a_line,
    output logic [LINE_W-1:0] b_line
);
    logic [LINE_W-1:0] mem_d [LINES];
    logic [LINE_W-1:0] mem_q [LINES];

    always_comb begin
        mem_d = mem_q;
        for (int w = 0; w < WORDS; w++) begin
            if (wr_mask[w])
                mem_d[wr_idx][w*DATA_W +: DATA_W] = wr_line[w*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign a_line = mem_q[a_idx];
    assign b_line = mem_q[b_idx];
endmodule

// File: rtl/upd_snoop_ctrl.sv
module upd_snoop_ctrl
    import ucoh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_word,
    output logic [LINE_W-1:0] bus_line,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic [LINE_W-1:0] bus_fill,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_word,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [LINE_W-1:0] snp_line
);
    typedef struct packed {
        fsm_e              fsm;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // field split of the word address: tag | index | word offset
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx, snp_idx;
    logic [TAG_W-1:0]  cur_tag, snp_tag;
    logic [OFF_W-1:0]  cur_off, snp_off;

    logic              a_present, b_present;
    logic [TAG_W-1:0]  a_tag, b_tag;
    line_st_e          a_st, b_st;
    logic [LINE_W-1:0] a_line, b_line;

    logic              tw_en;
    logic [IDX_W-1:0]  tw_idx;
    logic [TAG_W-1:0]  tw_tag;
    line_st_e          tw_st;
    logic [IDX_W-1:0]  dw_idx;
    logic [WORDS-1:0]  dw_mask;
    logic [LINE_W-1:0] dw_line;

    logic              cpu_hit, snp_hit;
    logic [LINE_W-1:0] merged_fill;

    assign cur_addr = (ctl_q.fsm == FS_IDLE) ? cpu_addr : ctl_q.addr;
    assign cur_off  = cur_addr[OFF_W-1:0];
    assign cur_idx  = cur_addr[OFF_W +: IDX_W];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign snp_off  = snp_addr[OFF_W-1:0];
    assign snp_idx  = snp_addr[OFF_W +: IDX_W];
    assign snp_tag  = snp_addr[ADDR_W-1 -: TAG_W];

    ucoh_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk, .rst_n,
        .a_idx(cur_idx), .b_idx(snp_idx),
        .wr_en(tw_en), .wr_idx(tw_idx), .wr_tag(tw_tag), .wr_st(tw_st),
        .a_present, .a_tag, .a_st,
        .b_present, .b_tag, .b_st
    );

    ucoh_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk, .rst_n,
        .a_idx(cur_idx), .b_idx(snp_idx),
        .wr_idx(dw_idx), .wr_mask(dw_mask), .wr_line(dw_line),
        .a_line, .b_line
    );

    assign cpu_hit = a_present && (a_tag == cur_tag);
    assign snp_hit = snp_valid && b_present && (b_tag == snp_tag)
                     && (snp_cmd != BC_FLUSH) && (snp_cmd != BC_NONE);

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            merged_fill[w*DATA_W +: DATA_W] = (OFF_W'(w) == cur_off) ?
                ctl_q.wdata : bus_fill[w*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tw_en      = 1'b0;
        tw_idx     = cur_idx;
        tw_tag     = cur_tag;
        tw_st      = LS_EXCL;
        dw_idx     = cur_idx;
        dw_mask    = '0;
        dw_line    = '0;
        bus_req    = 1'b0;
        bus_cmd    = BC_NONE;
        bus_addr   = '0;
        bus_word   = '0;
        bus_line   = '0;
        snp_shared = 1'b0;
        snp_flush  = 1'b0;
        snp_line   = b_line;

        // local side
        unique case (ctl_q.fsm)
            FS_IDLE: begin
                if (cpu_req && !ctl_q.done && !snp_valid) begin
                    ctl_d.addr  = cpu_addr;
                    ctl_d.we    = cpu_we;
                    ctl_d.wdata = cpu_wdata;
                    if (cpu_hit) begin
                        if (!cpu_we) begin
                            ctl_d.done  = 1'b1;
                            ctl_d.rdata = a_line[cur_off*DATA_W +: DATA_W];
                        end else if (a_st == LS_EXCL || a_st == LS_MOD) begin
                            dw_mask          = '0;
                            dw_mask[cur_off] = 1'b1;
                            dw_line          = {WORDS{cpu_wdata}};
                            tw_en            = 1'b1;
                            tw_st            = LS_MOD;
                            ctl_d.done       = 1'b1;
                        end else begin
                            ctl_d.fsm = FS_UPDATE;
                        end
                    end else if (a_present && is_dirty(a_st)) begin
                        ctl_d.fsm = FS_WBACK;
                    end else begin
                        ctl_d.fsm = FS_FILL;
                    end
                end
            end
            FS_WBACK: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_FLUSH;
                bus_addr = {a_tag, cur_idx, {OFF_W{1'b0}}};
                bus_line = a_line;
                if (bus_gnt) ctl_d.fsm = FS_FILL;
            end
            FS_FILL: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_READ;
                bus_addr = {cur_tag, cur_idx, {OFF_W{1'b0}}};
                if (bus_gnt) begin
                    tw_en   = 1'b1;
                    dw_mask = '1;
                    if (!ctl_q.we) begin
                        dw_line     = bus_fill;
                        tw_st       = bus_shared_in ? LS_SHCLN : LS_EXCL;
                        ctl_d.rdata = bus_fill[cur_off*DATA_W +: DATA_W];
                        ctl_d.done  = 1'b1;
                        ctl_d.fsm   = FS_IDLE;
                    end else if (bus_shared_in) begin
                        dw_line   = bus_fill;
                        tw_st     = LS_SHCLN;
                        ctl_d.fsm = FS_UPDATE;
                    end else begin
                        dw_line    = merged_fill;
                        tw_st      = LS_MOD;
                        ctl_d.done = 1'b1;
                        ctl_d.fsm  = FS_IDLE;
                    end
                end
            end
            FS_UPDATE: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_UPDATE;
                bus_addr = ctl_q.addr;
                bus_word = ctl_q.wdata;
                if (bus_gnt) begin
                    dw_mask          = '0;
                    dw_mask[cur_off] = 1'b1;
                    dw_line          = {WORDS{ctl_q.wdata}};
                    tw_en            = 1'b1;
                    tw_st            = bus_shared_in ? LS_SHMOD : LS_MOD;
                    ctl_d.done       = 1'b1;
                    ctl_d.fsm        = FS_IDLE;
                end
            end
            default: ctl_d.fsm = FS_IDLE;
        endcase

        // snoop side; the bus never grants this cache while another one is snooped
        if (snp_hit) begin
            snp_shared = 1'b1;
            tw_en      = 1'b1;
            tw_idx     = snp_idx;
            tw_tag     = b_tag;
            if (snp_cmd == BC_READ) begin
                if (is_dirty(b_st)) begin
                    snp_flush = 1'b1;
                    tw_st     = LS_SHMOD;
                end else begin
                    tw_st     = LS_SHCLN;
                end
            end else begin
                dw_idx           = snp_idx;
                dw_mask          = '0;
                dw_mask[snp_off] = 1'b1;
                dw_line          = {WORDS{snp_word}};
                tw_st            = LS_SHCLN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{fsm: FS_IDLE, done: 1'b0, rdata: '0, addr: '0, we: 1'b0, wdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_done  = ctl_q.done;
    assign cpu_rdata = ctl_q.rdata;
endmodule

// File: rtl/ucoh_chk.sv
module ucoh_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_shared,
    input logic              snp_flush
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));
    // R10
    req_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_cmd != 2'd0);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
    // R7
    flush_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_valid && snp_cmd == 2'd1 && snp_shared);
    // R12
    snoop_flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_cmd == 2'd3 |-> !snp_shared && !snp_flush);
    // R6
    wb_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && bus_cmd == 2'd3 |=> bus_req && bus_cmd == 2'd1);
    // R5
    update_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && bus_cmd == 2'd2 |=> cpu_done);
endmodule

bind upd_snoop_ctrl ucoh_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/sim_upd_snoop_ctrl.sv
module sim_upd_snoop_ctrl;
    localparam int AW = 8, DW = 16, NW = 4, LW = NW * DW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_word;
    logic [LW-1:0] bus_line;
    logic bus_gnt = 0, bus_shared_in = 0;
    logic [LW-1:0] bus_fill = '0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_word = '0;
    logic snp_shared, snp_flush;
    logic [LW-1:0] snp_line;

    always #10 clk = ~clk;

    upd_snoop_ctrl u0 (.*);

    int n_run = 0, n_fail = 0;
    logic [DW-1:0] mem   [256];
    logic [DW-1:0] ref_v [256];

    task automatic check(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    // one processor access with a bus responder that grants every other cycle
    task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic shr, output logic [DW-1:0] rd,
                         output int n, output logic [5:0] seq);
        bit pend = 0;
        int guard = 0;
        n = 0; seq = '0; rd = '0;
        if (we) ref_v[a] = wd;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        forever begin
            @(negedge clk);
            bus_gnt = 0;
            guard++;
            if (guard > 60) begin
                check(0, "R10 operation hung", 64'(guard), 64'd0);
                break;
            end
            if (cpu_done) begin
                rd = cpu_rdata;
                cpu_req = 0;
                @(negedge clk);
                check(!cpu_done, "R11 done is one cycle", 64'(cpu_done), 64'd0);
                break;
            end
            if (bus_req) begin
                if (!pend) pend = 1;
                else begin
                    pend = 0;
                    if (n < 3) seq[2*n +: 2] = bus_cmd;
                    n++;
                    if (bus_cmd == 2'd3) begin
                        for (int w = 0; w < NW; w++) begin
                            check(bus_line[w*DW +: DW] == ref_v[bus_addr + AW'(w)],
                                  "R6 flushed word", 64'(bus_line[w*DW +: DW]), 64'(ref_v[bus_addr + AW'(w)]));
                            mem[bus_addr + AW'(w)] = bus_line[w*DW +: DW];
                        end
                    end else if (bus_cmd == 2'd2) begin
                        check(bus_addr == a && bus_word == wd, "R5 update address and word",
                              {bus_addr, bus_word}, {a, wd});
                    end else begin
                        for (int w = 0; w < NW; w++)
                            bus_fill[w*DW +: DW] = mem[bus_addr + AW'(w)];
                    end
                    bus_shared_in = shr;
                    bus_gnt = 1;
                end
            end
        end
        bus_gnt = 0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         output logic sh, output logic fl, output logic [LW-1:0] ln);
        @(negedge clk);
        snp_valid = 1; snp_cmd = c; snp_addr = a; snp_word = wd;
        #2;
        sh = snp_shared; fl = snp_flush; ln = snp_line;
        @(negedge clk);
        snp_valid = 0; snp_cmd = '0;
    endtask

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          shr;
        logic [1:0]    ncmd;
        logic [5:0]    seq;   // first command in bits 1:0; 1 read, 2 update, 3 flush
    } vec_t;

    localparam vec_t VECS [17] = '{
        '{1'b0, 8'h04, 16'h0000, 1'b0, 2'd1, 6'h01},
        '{1'b0, 8'h05, 16'h0000, 1'b0, 2'd0, 6'h00},
        '{1'b1, 8'h06, 16'h1111, 1'b0, 2'd0, 6'h00},
        '{1'b0, 8'h06, 16'h0000, 1'b0, 2'd0, 6'h00},
        '{1'b0, 8'h24, 16'h0000, 1'b1, 2'd2, 6'h07},
        '{1'b1, 8'h25, 16'h2222, 1'b1, 2'd1, 6'h02},
        '{1'b1, 8'h25, 16'h3333, 1'b0, 2'd1, 6'h02},
        '{1'b1, 8'h26, 16'h4444, 1'b0, 2'd0, 6'h00},
        '{1'b0, 8'h06, 16'h0000, 1'b0, 2'd2, 6'h07},
        '{1'b1, 8'h48, 16'h5555, 1'b1, 2'd2, 6'h09},
        '{1'b0, 8'h68, 16'h0000, 1'b0, 2'd2, 6'h07},
        '{1'b0, 8'h88, 16'h0000, 1'b0, 2'd1, 6'h01},
        '{1'b1, 8'h0C, 16'h6666, 1'b0, 2'd1, 6'h01},
        '{1'b1, 8'h0D, 16'h7777, 1'b0, 2'd0, 6'h00},
        '{1'b0, 8'h2C, 16'h0000, 1'b1, 2'd2, 6'h07},
        '{1'b0, 8'h10, 16'h0000, 1'b1, 2'd1, 6'h01},
        '{1'b1, 8'h30, 16'h8888, 1'b0, 2'd1, 6'h01}
    };

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int n;
        logic [5:0] seq;
        logic sh, fl;
        logic [LW-1:0] ln;

        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'h5000 + 16'(i);
            ref_v[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(!cpu_done && !bus_req, "R1 idle after reset", {cpu_done, bus_req}, 0);
        snoop(2'd1, 8'h04, 16'h0, sh, fl, ln);
        check(!sh && !fl, "R1 no line present after reset", {sh, fl}, 0);

        // R2 R3 R4 R5 R6 table of processor accesses
        foreach (VECS[i]) begin
            do_op(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].shr, rd, n, seq);
            check(n == int'(VECS[i].ncmd), $sformatf("R2 R3 R4 R5 R6 bus count vec %0d", i),
                  64'(n), 64'(VECS[i].ncmd));
            check(seq == VECS[i].seq, $sformatf("R2 R3 R5 R6 bus order vec %0d", i),
                  64'(seq), 64'(VECS[i].seq));
            if (!VECS[i].we)
                check(rd == ref_v[VECS[i].addr], $sformatf("R2 read data vec %0d", i),
                      64'(rd), 64'(ref_v[VECS[i].addr]));
        end

        // R7 snooped read on a sole-clean line: shared, no flush, becomes shared-clean
        snoop(2'd1, 8'h88, 16'h0, sh, fl, ln);
        check(sh && !fl, "R7 clean line answers shared without flush", {sh, fl}, 2'b10);
        do_op(1'b1, 8'h89, 16'hA1A1, 1'b1, rd, n, seq);
        check(n == 1 && seq == 6'h02, "R7 line now shared, store sends update", 64'(seq), 64'h2);

        // R7 snooped read on the owner line: flush with current data, stays owner
        snoop(2'd1, 8'h8B, 16'h0, sh, fl, ln);
        check(sh && fl, "R7 owner flushes", {sh, fl}, 2'b11);
        check(ln[1*DW +: DW] == 16'hA1A1, "R7 flushed line carries stored word", 64'(ln[DW +: DW]), 64'hA1A1);

        // R12 snooped flush is ignored
        snoop(2'd3, 8'h88, 16'h0, sh, fl, ln);
        check(!sh && !fl, "R12 snooped flush gives no response", {sh, fl}, 0);
        snoop(2'd1, 8'h88, 16'h0, sh, fl, ln);
        check(fl, "R12 R7 owner state kept after flush snoop", 64'(fl), 64'd1);

        // R8 snooped update writes the word and leaves the line shared-clean
        snoop(2'd2, 8'h8A, 16'hBEEF, sh, fl, ln);
        ref_v[8'h8A] = 16'hBEEF;
        check(sh, "R8 update snoop hits", 64'(sh), 64'd1);
        do_op(1'b0, 8'h8A, 16'h0, 1'b0, rd, n, seq);
        check(n == 0 && rd == 16'hBEEF, "R8 R9 snooped word read as hit", {32'(n), 16'h0, rd}, {32'd0, 16'h0, 16'hBEEF});
        snoop(2'd1, 8'h88, 16'h0, sh, fl, ln);
        check(sh && !fl, "R8 line is shared-clean after update", {sh, fl}, 2'b10);

        // R8 update to an absent line has no effect
        snoop(2'd2, 8'hE0, 16'hDEAD, sh, fl, ln);
        check(!sh, "R8 absent line not shared", 64'(sh), 0);
        do_op(1'b0, 8'hE0, 16'h0, 1'b0, rd, n, seq);
        check(n == 1 && rd == mem[8'hE0], "R8 absent line still misses with memory data",
              {32'(n), 16'h0, rd}, {32'd1, 16'h0, mem[8'hE0]});

        // R9 snoops on a sole-dirty line never remove it
        snoop(2'd1, 8'h31, 16'h0, sh, fl, ln);
        check(sh && fl, "R9 R7 sole-dirty line flushes on snooped read", {sh, fl}, 2'b11);
        snoop(2'd2, 8'h32, 16'hC0DE, sh, fl, ln);
        ref_v[8'h32] = 16'hC0DE;
        do_op(1'b0, 8'h32, 16'h0, 1'b0, rd, n, seq);
        check(n == 0 && rd == 16'hC0DE, "R9 line still present after snoops",
              {32'(n), 16'h0, rd}, {32'd0, 16'h0, 16'hC0DE});
        do_op(1'b0, 8'h30, 16'h0, 1'b0, rd, n, seq);
        check(n == 0 && rd == 16'h8888, "R9 R3 earlier stored word kept",
              {32'(n), 16'h0, rd}, {32'd0, 16'h0, 16'h8888});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule